// File: doc/BRIEF.md
# Prioritized Error Address Capture Register

This block records where a memory controller's accesses went wrong. Four kinds of error event feed it, each as a single-cycle pulse carrying the failing double-word address. In falling order of rank they are: an uncorrectable ECC error, a read-while-write conflict, a failed program/erase operation and a corrected single-bit ECC error. Each class has its own sticky flag and its own address slot. A slot keeps the first address of its class until software clears that class's flag. The 32-bit status word always shows the slot of the highest-ranked class whose flag is set, so a later event of higher rank takes over the view and a lower-ranked one never does.

Only bits 22 down to 3 of an address are kept, because every capture names a 64-bit double word. When an uncorrectable or a corrected error hits both double words of a page in the same cycle, the stored double-word select bit is forced to zero. Capture of corrected errors is gated by a configuration input. With no flag set, the word shows a holding value. That value tracks the most recent capture, and a supervisor-mode bus write can load it. In user mode the bus cannot write it.

Top module: `errAddrCapture`

## Requirements
- R1: After reset all four flags are 0 and busRdData reads 0.
- R2: An event of a class whose flag is clear stores its address bits 22:3 in that class's slot and sets the flag, which is visible after the next clock edge. While that flag stays set, further events of the same class change neither the slot nor the read value.
- R3: flags bit 0 is the uncorrectable ECC class, bit 1 is read-while-write, bit 2 is program/erase failure and bit 3 is corrected ECC. Priority falls with the bit index. While any flag is set, busRdData shows the slot of the lowest-indexed set flag.
- R4: busRdData carries the stored address in bits 22:3. Bits 31:23 and 2:0 always read 0.
- R5: If dedPair is high with dedPulse, or secPair is high with secPulse, the stored bit 3 of that capture is 0 whatever the event address.
- R6: A corrected-ECC pulse is captured only while secCaptureEn is 1. When it is 0, flag bit 3 and the slot are left unchanged.
- R7: A program/erase failure is seen when peDone is high and pePass is low. peDone with pePass high captures nothing.
- R8: A 1 on flagClr[k] clears flag k after the clock edge and re-arms its class. When flagClr[k] and an event of class k arrive while flag k is set, the flag clears and that event is discarded.
- R9: With no flag set, busRdData shows the holding value. Every capture cycle loads the holding value with the address of the highest-ranked class captured in that cycle.
- R10: A bus write with supervisor high loads busWrData[22:3] into the holding value, unless some class captures in the same cycle. In that case the capture wins and the write is lost.
- R11: A bus write with supervisor low has no effect on the read value or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dedPulse | input | 1 | Uncorrectable ECC error event |
| dedPair | input | 1 | Uncorrectable error on both double words of the page |
| dedAddr | input | 20 | Failing address bits 22:3 for dedPulse |
| rwwPulse | input | 1 | Read-while-write conflict event |
| rwwAddr | input | 20 | Failing address bits 22:3 for rwwPulse |
| peDone | input | 1 | Program/erase operation completed |
| pePass | input | 1 | Pass indication sampled with peDone |
| peAddr | input | 20 | Address bits 22:3 of the operation |
| secPulse | input | 1 | Corrected single-bit ECC event |
| secPair | input | 1 | Correction on both double words of the page |
| secAddr | input | 20 | Address bits 22:3 for secPulse |
| secCaptureEn | input | 1 | Enables capture of corrected-ECC events |
| flagClr | input | 4 | Per-class flag clear, write-1 |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 32 | Bus write data |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| busRdData | output | 32 | Status word |
| flags | output | 4 | Per-class sticky flags |

## Verification
Several pairs of functions can land in the same clock cycle: a bus write with a capture, and a clear with a new event of the same class. The bench provokes both on purpose in directed steps. A supervisor write is issued together with a read-while-write pulse, and the read value must show the event address, both while the flag is set and after the flag is cleared. A clear is issued together with a repeat event on a set flag, and the flag must drop while the old address stays in the slot. The randomized phase then raises events, clears and writes together at high rates, and a bench model scores every cycle.

// File: rtl/errCapPkg.sv
package errCapPkg;
  localparam int NUM_CLS = 4;
  localparam int SEL_W   = 2;
  localparam int CLS_DED = 0;
  localparam int CLS_RWW = 1;
  localparam int CLS_PE  = 2;
  localparam int CLS_SEC = 3;

  typedef struct packed {
    logic [NUM_CLS-1:0] capture;
    logic               anyFlag;
    logic [SEL_W-1:0]   rdSel;
    logic               heldLoadCap;
    logic [SEL_W-1:0]   heldCapSel;
    logic               heldLoadWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/errCapCtrl.sv
module errCapCtrl
  import errCapPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CLS-1:0] evtHit,
  input  logic [NUM_CLS-1:0] flagClr,
  input  logic               wrReq,
  output logic [NUM_CLS-1:0] flags,
  output ctrlStrobes_t       strobes
);

  function automatic logic [SEL_W-1:0] firstSet(input logic [NUM_CLS-1:0] v);
    logic [SEL_W-1:0] r;
    r = '0;
    for (int i = NUM_CLS - 1; i >= 0; i--) begin
      if (v[i]) r = SEL_W'(i);
    end
    return r;
  endfunction

  logic [NUM_CLS-1:0] capture;

  always_comb begin
    capture             = evtHit & ~flags;
    strobes.capture     = capture;
    strobes.anyFlag     = |flags;
    strobes.rdSel       = firstSet(flags);
    strobes.heldLoadCap = |capture;
    strobes.heldCapSel  = firstSet(capture);
    strobes.heldLoadWr  = wrReq & ~(|capture);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= capture | (flags & ~flagClr);
  end

  // R2: a class with a clear flag that sees an event gets its flag set
  p_capture_sets_flag_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (evtHit[CLS_DED] && !flags[CLS_DED]) |=> flags[CLS_DED]);

  generate
    for (genvar k = 0; k < NUM_CLS; k++) begin : g_clrChk
      // R8: clear with flag set always wins over a same-class event
      p_clear_drops_flag_r8 : assert property (@(posedge clk) disable iff (!rstN)
        (flags[k] && flagClr[k]) |=> !flags[k]);
    end
  endgenerate

endmodule

// File: rtl/errCapData.sv
module errCapData
  import errCapPkg::*;
#(
  parameter int AW = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [NUM_CLS-1:0][AW-1:0]  evtAddr,
  input  logic [AW-1:0]               wrAddr,
  output logic [AW-1:0]               rdAddr
);

  logic [NUM_CLS-1:0][AW-1:0] clsAddr;
  logic [AW-1:0]              heldAddr;

  generate
    for (genvar k = 0; k < NUM_CLS; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN)                  clsAddr[k] <= '0;
        else if (strobes.capture[k]) clsAddr[k] <= evtAddr[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                   heldAddr <= '0;
    else if (strobes.heldLoadCap) heldAddr <= evtAddr[strobes.heldCapSel];
    else if (strobes.heldLoadWr)  heldAddr <= wrAddr;
  end

  assign rdAddr = strobes.anyFlag ? clsAddr[strobes.rdSel] : heldAddr;

  // R10: an accepted write with no flag pending shows up on the read path next cycle
  p_write_load_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.heldLoadWr && !strobes.anyFlag) |=> (rdAddr == $past(wrAddr)));

endmodule

// File: rtl/errAddrCapture.sv
module errAddrCapture
  import errCapPkg::*;
#(
  parameter int ADDR_HI = 22,
  parameter int ADDR_LO = 3,
  parameter int BUS_W   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     dedPulse,
  input  logic                     dedPair,
  input  logic [ADDR_HI:ADDR_LO]   dedAddr,
  input  logic                     rwwPulse,
  input  logic [ADDR_HI:ADDR_LO]   rwwAddr,
  input  logic                     peDone,
  input  logic                     pePass,
  input  logic [ADDR_HI:ADDR_LO]   peAddr,
  input  logic                     secPulse,
  input  logic                     secPair,
  input  logic [ADDR_HI:ADDR_LO]   secAddr,
  input  logic                     secCaptureEn,
  input  logic [3:0]               flagClr,
  input  logic                     busWrEn,
  input  logic [BUS_W-1:0]         busWrData,
  input  logic                     supervisor,
  output logic [BUS_W-1:0]         busRdData,
  output logic [3:0]               flags
);

  localparam int AW    = ADDR_HI - ADDR_LO + 1;
  localparam int TOP_Z = BUS_W - ADDR_HI - 1;

  ctrlStrobes_t               strobes;
  logic [NUM_CLS-1:0]         evtHit;
  logic [NUM_CLS-1:0][AW-1:0] evtAddr;
  logic [NUM_CLS-1:0]         pairHit;
  logic [AW-1:0]              rdAddr;
  logic                       unusedWrBits;

  assign evtHit[CLS_DED] = dedPulse;
  assign evtHit[CLS_RWW] = rwwPulse;
  assign evtHit[CLS_PE]  = peDone & ~pePass;
  assign evtHit[CLS_SEC] = secPulse & secCaptureEn;

  assign pairHit = {secPair, 1'b0, 1'b0, dedPair};

  logic [NUM_CLS-1:0][AW-1:0] rawAddr;
  assign rawAddr[CLS_DED] = dedAddr;
  assign rawAddr[CLS_RWW] = rwwAddr;
  assign rawAddr[CLS_PE]  = peAddr;
  assign rawAddr[CLS_SEC] = secAddr;

  generate
    for (genvar k = 0; k < NUM_CLS; k++) begin : g_pairMask
      assign evtAddr[k] = {rawAddr[k][AW-1:1], rawAddr[k][0] & ~pairHit[k]};
    end
  endgenerate

  assign unusedWrBits = ^{busWrData[BUS_W-1:ADDR_HI+1], busWrData[ADDR_LO-1:0]};

  errCapCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evtHit  (evtHit),
    .flagClr (flagClr),
    .wrReq   (busWrEn & supervisor),
    .flags   (flags),
    .strobes (strobes)
  );

  errCapData #(.AW(AW)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .evtAddr (evtAddr),
    .wrAddr  (busWrData[ADDR_HI:ADDR_LO]),
    .rdAddr  (rdAddr)
  );

  assign busRdData = {{TOP_Z{1'b0}}, rdAddr, {ADDR_LO{1'b0}}};

  // R2: the highest class view holds while its flag is not cleared
  p_ded_hold_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (flags[CLS_DED] && !flagClr[CLS_DED]) |=> $stable(busRdData));

  // R5: a page-pair uncorrectable capture shows bit 3 low
  p_pair_bit_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (dedPulse && dedPair && !flags[CLS_DED]) |=> (busRdData[ADDR_LO] == 1'b0));

  // R6: corrected errors are not flagged while capture is disabled
  p_sec_gate_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (!secCaptureEn && !flags[CLS_SEC]) |=> !flags[CLS_SEC]);

  // R7: a passing program/erase completion raises no flag
  p_pe_pass_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (peDone && pePass && !flags[CLS_PE]) |=> !flags[CLS_PE]);

  // R11: with nothing flagged and nothing captured, a user-mode cycle leaves the view alone
  p_user_write_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (!(|flags) && !supervisor && !(|evtHit)) |=> $stable(busRdData));

endmodule

// File: tb/errAddrCapture_tb.sv
`timescale 1ns/1ps
module errAddrCapture_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dedPulse = 0, dedPair = 0, rwwPulse = 0, peDone = 0, pePass = 0;
  logic        secPulse = 0, secPair = 0, secCaptureEn = 0;
  logic [22:3] dedAddr = '0, rwwAddr = '0, peAddr = '0, secAddr = '0;
  logic [3:0]  flagClr = '0;
  logic        busWrEn = 0, supervisor = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [3:0]  mFlag;
  logic [19:0] mAddr [4];
  logic [19:0] mHeld;

  always #2 clk = ~clk;

  errAddrCapture dut_i (
    .clk(clk), .rstN(rstN),
    .dedPulse(dedPulse), .dedPair(dedPair), .dedAddr(dedAddr),
    .rwwPulse(rwwPulse), .rwwAddr(rwwAddr),
    .peDone(peDone), .pePass(pePass), .peAddr(peAddr),
    .secPulse(secPulse), .secPair(secPair), .secAddr(secAddr),
    .secCaptureEn(secCaptureEn), .flagClr(flagClr),
    .busWrEn(busWrEn), .busWrData(busWrData), .supervisor(supervisor),
    .busRdData(busRdData), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead();
    for (int k = 0; k < 4; k++) if (mFlag[k]) return {9'b0, mAddr[k], 3'b0};
    return {9'b0, mHeld, 3'b0};
  endfunction

  task automatic idle();
    dedPulse = 0; dedPair = 0; rwwPulse = 0; peDone = 0; pePass = 0;
    secPulse = 0; secPair = 0; flagClr = '0; busWrEn = 0;
  endtask

  // one clock: reference update from the applied inputs, then compare
  task automatic tick();
    logic [3:0]  hit, cap, nFlag;
    logic [19:0] ea [4];
    logic [19:0] nHeld;
    hit = {secPulse & secCaptureEn, peDone & ~pePass, rwwPulse, dedPulse};
    ea[0] = {dedAddr[22:4], dedAddr[3] & ~dedPair};
    ea[1] = rwwAddr;
    ea[2] = peAddr;
    ea[3] = {secAddr[22:4], secAddr[3] & ~secPair};
    cap = hit & ~mFlag;
    nFlag = cap | (mFlag & ~flagClr);
    nHeld = mHeld;
    if (|cap) begin
      for (int k = 3; k >= 0; k--) if (cap[k]) nHeld = ea[k];
    end else if (busWrEn && supervisor) nHeld = busWrData[22:3];
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) if (cap[k]) mAddr[k] = ea[k];
    mFlag = nFlag;
    mHeld = nHeld;
    idle();
    chk("R8 flags", {28'b0, flags}, {28'b0, mFlag});
    chk("R3 read", busRdData, expRead());
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog actual=running expected=finished");
    failures++;
    if (!done) begin
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mFlag = '0; mHeld = '0;
    for (int k = 0; k < 4; k++) mAddr[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {28'b0, flags}, 32'h0);
    chk("R1 read", busRdData, 32'h0);

    // R2 first capture, then same class ignored
    rwwPulse = 1; rwwAddr = 20'h1_2345; tick();
    chk("R2 first", busRdData, {9'b0, 20'h1_2345, 3'b0});
    rwwPulse = 1; rwwAddr = 20'h0_0F0F; tick();
    chk("R2 same class kept", busRdData, {9'b0, 20'h1_2345, 3'b0});

    // R3 higher class overrides the view
    dedPulse = 1; dedAddr = 20'hA_BCDE; tick();
    chk("R3 override", busRdData, {9'b0, 20'hA_BCDE, 3'b0});
    flagClr = 4'b0001; tick();
    chk("R3 fall back", busRdData, {9'b0, 20'h1_2345, 3'b0});

    // R9 with no flag the holding value shows the latest capture
    flagClr = 4'b0010; tick();
    chk("R9 held", busRdData, {9'b0, 20'hA_BCDE, 3'b0});

    // R7 pass completion ignored, fail captured
    peDone = 1; pePass = 1; peAddr = 20'h3_3333; tick();
    chk("R7 pass", {28'b0, flags}, 32'h0);
    peDone = 1; pePass = 0; peAddr = 20'h4_4444; tick();
    chk("R7 fail", busRdData, {9'b0, 20'h4_4444, 3'b0});

    // R6 gated corrected error, then enabled with page pair (R5)
    secCaptureEn = 0; secPulse = 1; secAddr = 20'h5_5555; tick();
    chk("R6 gated", {28'b0, flags}, 32'h4);
    secCaptureEn = 1; secPulse = 1; secPair = 1; secAddr = 20'h7_7777; tick();
    flagClr = 4'b0100; tick();
    chk("R5 sec pair", busRdData, {9'b0, 20'h7_7776, 3'b0});
    flagClr = 4'b1000; tick();

    // R5 uncorrectable page pair
    dedPulse = 1; dedPair = 1; dedAddr = 20'hF_FFFF; tick();
    chk("R5 ded pair", busRdData, {9'b0, 20'hF_FFFE, 3'b0});
    // R8 clear and repeat event together: flag drops, event lost
    flagClr = 4'b0001; dedPulse = 1; dedAddr = 20'h1_1111; tick();
    chk("R8 clear wins", {28'b0, flags}, 32'h0);
    chk("R8 slot kept", busRdData, {9'b0, 20'hF_FFFE, 3'b0});

    // R11 user write ignored
    supervisor = 0; busWrEn = 1; busWrData = 32'hFFFF_FFFF; tick();
    chk("R11 user", busRdData, {9'b0, 20'hF_FFFE, 3'b0});
    // R10 and R4 supervisor write, junk outside 22:3 dropped
    supervisor = 1; busWrEn = 1; busWrData = 32'hFF9A_BCDF; tick();
    chk("R4 R10 write", busRdData, {9'b0, 32'hFF9A_BCDF >> 3 & 20'hF_FFFF, 3'b0});
    // R10 capture beats a write in the same cycle
    busWrEn = 1; busWrData = 32'h0000_0008; rwwPulse = 1; rwwAddr = 20'h2_2222; tick();
    flagClr = 4'b0010; tick();
    chk("R10 capture wins", busRdData, {9'b0, 20'h2_2222, 3'b0});

    // randomized phase
    for (int n = 0; n < 4000; n++) begin
      dedPulse = ($urandom % 8) == 0; dedPair = $urandom % 2; dedAddr = 20'($urandom);
      rwwPulse = ($urandom % 6) == 0; rwwAddr = 20'($urandom);
      peDone = ($urandom % 5) == 0; pePass = $urandom % 2; peAddr = 20'($urandom);
      secPulse = ($urandom % 3) == 0; secPair = $urandom % 2; secAddr = 20'($urandom);
      secCaptureEn = ($urandom % 4) != 0;
      flagClr = 4'($urandom) & 4'($urandom);
      busWrEn = ($urandom % 3) == 0; busWrData = $urandom; supervisor = $urandom % 2;
      tick();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule